// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and calendar date as seven packed-BCD registers: seconds, minutes, hours, date, month, day of week and two-digit year. A one-cycle pulse on `tick_i`, generated elsewhere once per second, advances the seconds. Each field carries into the next one in turn, from seconds up to the year. Month length follows the calendar, with February given 29 days in every year whose number is divisible by four. That rule is correct for 2000 to 2099.

Software loads any field through a synchronous write port and reads any field through a combinational read port. Bit 7 of the hours register selects the hour format. Bit 7 of the seconds register stops all counting while it is set.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode), date 0x01, month 0x01, day of week 0x01 and year 0x00. Field addresses are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week, 6 year.
- R2: Each counted tick advances the seconds in BCD. Seconds roll 0x59 to 0x00 and carry into minutes. Minutes roll 0x59 to 0x00 and carry into hours.
- R3: With hours bit 7 at 0 (24-hour mode), hours count 0x00 to 0x23. Bit 5 is the tens-of-hours bit for 20 to 23. A carry out of 0x23 wraps the hours to 0x00 and advances the date.
- R4: With hours bit 7 at 1 (12-hour mode), bits 4:0 hold 01 to 12 and bit 5 is the PM flag (1 = PM). A carry at 11 gives 12 and toggles the flag. A carry at 12 gives 01. A carry at 11 with PM set also advances the date.
- R5: A date carry at or past the month's last day gives date 0x01 and advances the month. April, June, September and November have 30 days. The other months have 31, except February.
- R6: February has 29 days when the year's value is divisible by 4, and 28 days otherwise.
- R7: A month carry from 0x12 gives month 0x01 and advances the year. The year rolls 0x99 to 0x00.
- R8: Every date carry advances the day of week, and 7 wraps to 1.
- R9: While seconds bit 7 is 1, ticks change no field. Writing the bit to 0 lets counting resume.
- R10: A write to a field in the same cycle as a tick that would change it stores the written value.
- R11: Reads return 0 in the unused bits: minutes bit 7, hours bit 6, date bits 7:6, month bits 7:5 and day-of-week bits 7:3. Address 7 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| wr_en_i | input | 1 | Field write strobe |
| wr_addr_i | input | 3 | Field address for the write |
| wr_data_i | input | 8 | Register image to write |
| rd_addr_i | input | 3 | Field address for the read |
| rd_data_o | output | 8 | Register image at rd_addr_i |

## Verification
The hardest events to reach are the carries that ripple through all seven fields, such as New Year's Eve at 23:59:59 or 11:59:59 PM on a leap-year February 29. Reaching them by ticking alone would take years of ticks. The stimulus therefore writes every field to one second before each boundary and then sends a single tick. A randomized phase loads fields with values biased toward their last legal value, sometimes in the same cycle as a tick. This exercises write priority and partial carries.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int FIELD_ADDR_W = 3;
  localparam int REG_W        = 8;

  typedef logic [REG_W-1:0] reg_t;

  localparam logic [FIELD_ADDR_W-1:0] A_SEC  = 3'd0;
  localparam logic [FIELD_ADDR_W-1:0] A_MIN  = 3'd1;
  localparam logic [FIELD_ADDR_W-1:0] A_HOUR = 3'd2;
  localparam logic [FIELD_ADDR_W-1:0] A_DATE = 3'd3;
  localparam logic [FIELD_ADDR_W-1:0] A_MON  = 3'd4;
  localparam logic [FIELD_ADDR_W-1:0] A_DOW  = 3'd5;
  localparam logic [FIELD_ADDR_W-1:0] A_YEAR = 3'd6;

  // add one to a two-digit packed BCD value
  function automatic reg_t bcd_inc(reg_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // value divisible by four: even tens need units 0/4/8, odd tens need 2/6
  function automatic logic is_leap(reg_t yr);
    if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    else        return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  // last date of a month, as BCD
  function automatic reg_t month_len(reg_t mon, reg_t yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_clock_core.sv
module rtc_clock_core
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = FIELD_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  reg_t              wr_data_i,
  output reg_t              sec_o,
  output reg_t              min_o,
  output reg_t              hour_o,
  output logic              day_carry_o
);
  reg_t sec_q, min_q, hr_q;
  reg_t sec_nx, min_nx, hr_nx;
  reg_t inc12, inc24;

  logic wr_sec, wr_min, wr_hr;
  logic tick_en, min_inc, hour_inc, day_carry;

  assign wr_sec = wr_en_i && (wr_addr_i == A_SEC);
  assign wr_min = wr_en_i && (wr_addr_i == A_MIN);
  assign wr_hr  = wr_en_i && (wr_addr_i == A_HOUR);

  // carry chain, all taken from the current register values
  assign tick_en   = tick_i && !sec_q[7];
  assign min_inc   = tick_en && (sec_q[6:0] >= 7'h59);
  assign hour_inc  = min_inc && (min_q[6:0] >= 7'h59);
  assign day_carry = hour_inc && (hr_q[7] ? (hr_q[4:0] == 5'h11 && hr_q[5])
                                          : (hr_q[5:0] >= 6'h23));

  assign inc12 = bcd_inc({3'b000, hr_q[4:0]});
  assign inc24 = bcd_inc({2'b00, hr_q[5:0]});

  always_comb begin
    sec_nx = sec_q;
    if (tick_en) sec_nx = min_inc ? 8'h00 : bcd_inc({1'b0, sec_q[6:0]});
    if (wr_sec)  sec_nx = wr_data_i;

    min_nx = min_q;
    if (min_inc) min_nx = hour_inc ? 8'h00 : bcd_inc(min_q);
    if (wr_min)  min_nx = {1'b0, wr_data_i[6:0]};

    hr_nx = hr_q;
    if (hour_inc) begin
      if (hr_q[7]) begin
        if (hr_q[4:0] == 5'h12) hr_nx[4:0] = 5'h01;
        else if (hr_q[4:0] == 5'h11) begin
          hr_nx[4:0] = 5'h12;
          hr_nx[5]   = ~hr_q[5];
        end else hr_nx[4:0] = inc12[4:0];
      end else begin
        hr_nx[5:0] = (hr_q[5:0] >= 6'h23) ? 6'h00 : inc24[5:0];
      end
    end
    if (wr_hr) hr_nx = {wr_data_i[7], 1'b0, wr_data_i[5:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= 8'h00;
      min_q <= 8'h00;
      hr_q  <= 8'h00;
    end else begin
      sec_q <= sec_nx;
      min_q <= min_nx;
      hr_q  <= hr_nx;
    end
  end

  assign sec_o       = sec_q;
  assign min_o       = min_q;
  assign hour_o      = hr_q;
  assign day_carry_o = day_carry;

  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && sec_q == 8'h59 && !wr_sec) |=> (sec_q == 8'h00 && min_q != $past(min_q)));

  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q[7] && !wr_en_i) |=> ($stable(sec_q) && $stable(min_q) && $stable(hr_q)));

  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sec |=> (sec_q == $past(wr_data_i)));

  p_pm_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_inc && hr_q[7] && hr_q[4:0] == 5'h11 && !wr_hr)
      |=> (hr_q[4:0] == 5'h12 && hr_q[5] != $past(hr_q[5])));

  p_day_24h_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_inc && hr_q == 8'h23 && !wr_hr) |=> (hr_q == 8'h00));
endmodule

// File: rtl/rtc_date_core.sv
module rtc_date_core
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = FIELD_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              day_carry_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  reg_t              wr_data_i,
  output reg_t              date_o,
  output reg_t              mon_o,
  output reg_t              dow_o,
  output reg_t              year_o
);
  reg_t date_q, mon_q, dow_q, yr_q;
  reg_t date_nx, mon_nx, dow_nx, yr_nx;
  reg_t last_date;

  logic wr_date, wr_mon, wr_dow, wr_yr;
  logic mon_inc, year_inc;

  assign wr_date = wr_en_i && (wr_addr_i == A_DATE);
  assign wr_mon  = wr_en_i && (wr_addr_i == A_MON);
  assign wr_dow  = wr_en_i && (wr_addr_i == A_DOW);
  assign wr_yr   = wr_en_i && (wr_addr_i == A_YEAR);

  assign last_date = month_len(mon_q, yr_q);
  assign mon_inc   = day_carry_i && (date_q >= last_date);
  assign year_inc  = mon_inc && (mon_q >= 8'h12);

  always_comb begin
    date_nx = date_q;
    if (day_carry_i) date_nx = mon_inc ? 8'h01 : bcd_inc(date_q);
    if (wr_date)     date_nx = {2'b00, wr_data_i[5:0]};

    mon_nx = mon_q;
    if (mon_inc) mon_nx = year_inc ? 8'h01 : bcd_inc(mon_q);
    if (wr_mon)  mon_nx = {3'b000, wr_data_i[4:0]};

    dow_nx = dow_q;
    if (day_carry_i) dow_nx = (dow_q >= 8'h07) ? 8'h01 : dow_q + 8'h01;
    if (wr_dow)      dow_nx = {5'b00000, wr_data_i[2:0]};

    yr_nx = yr_q;
    if (year_inc) yr_nx = (yr_q >= 8'h99) ? 8'h00 : bcd_inc(yr_q);
    if (wr_yr)    yr_nx = wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      dow_q  <= 8'h01;
      yr_q   <= 8'h00;
    end else begin
      date_q <= date_nx;
      mon_q  <= mon_nx;
      dow_q  <= dow_nx;
      yr_q   <= yr_nx;
    end
  end

  assign date_o = date_q;
  assign mon_o  = mon_q;
  assign dow_o  = dow_q;
  assign year_o = yr_q;

  p_dow_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry_i && dow_q == 8'h07 && !wr_dow) |=> (dow_q == 8'h01));

  p_year_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (year_inc && yr_q == 8'h99 && !wr_yr) |=> (yr_q == 8'h00 && mon_q == 8'h01));

  p_feb_leap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry_i && mon_q == 8'h02 && date_q == 8'h28 && !wr_date && !wr_yr && !wr_mon)
      |=> (date_q == ($past(yr_q[1:0] == 2'b00 && !$past(yr_q[4]) ||
                            $past(yr_q[4]) && $past(yr_q[1:0]) == 2'b10) ? 8'h29 : 8'h01)));

  p_no_carry_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!day_carry_i && !wr_en_i) |=> ($stable(date_q) && $stable(mon_q) && $stable(yr_q)));
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = FIELD_ADDR_W,
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  reg_t sec_w, min_w, hour_w, date_w, mon_w, dow_w, year_w;
  logic day_carry_w;

  rtc_clock_core #(.ADDR_W(ADDR_W)) u_clock (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .sec_o(sec_w), .min_o(min_w), .hour_o(hour_w), .day_carry_o(day_carry_w)
  );

  rtc_date_core #(.ADDR_W(ADDR_W)) u_date (
    .clk(clk), .rst_n(rst_n), .day_carry_i(day_carry_w),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .date_o(date_w), .mon_o(mon_w), .dow_o(dow_w), .year_o(year_w)
  );

  always_comb begin
    case (rd_addr_i)
      A_SEC:   rd_data_o = sec_w;
      A_MIN:   rd_data_o = min_w;
      A_HOUR:  rd_data_o = hour_w;
      A_DATE:  rd_data_o = date_w;
      A_MON:   rd_data_o = mon_w;
      A_DOW:   rd_data_o = dow_w;
      A_YEAR:  rd_data_o = year_w;
      default: rd_data_o = '0;
    endcase
  end

  p_unused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (min_w[7] == 1'b0 && hour_w[6] == 1'b0 && date_w[7:6] == 2'b00 &&
     mon_w[7:5] == 3'b000 && dow_w[7:3] == 5'b00000));
endmodule

// File: tb/rtc_bcd_calendar_tb.sv
`timescale 1ns/100ps
module rtc_bcd_calendar_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = 3'd0;
  logic [7:0] wr_data_i = 8'h00;
  logic [2:0] rd_addr_i = 3'd0;
  logic [7:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state as plain integers
  int m_sec, m_min, m_hr, m_date, m_mon, m_dow, m_yr;
  bit m_halt, m_m12, m_pm;

  rtc_bcd_calendar u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  always #2.5 clk = ~clk;

  function automatic int to_bcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int from_bcd(int d);
    return ((d >> 4) & 15) * 10 + (d & 15);
  endfunction

  function automatic int days_in(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic int image(int a);
    case (a)
      0: return (int'(m_halt) << 7) | to_bcd(m_sec);
      1: return to_bcd(m_min);
      2: return m_m12 ? (8'h80 | (int'(m_pm) << 5) | to_bcd(m_hr)) : to_bcd(m_hr);
      3: return to_bcd(m_date);
      4: return to_bcd(m_mon);
      5: return m_dow;
      6: return to_bcd(m_yr);
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0, 1: return "R2";
      2: return m_m12 ? "R4" : "R3";
      3: return "R5";
      5: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic model_step(bit t, bit w, int a, int d);
    bit te, mc, hc, dc, mo, yc;
    te = t && !m_halt;
    mc = te && m_sec == 59;
    hc = mc && m_min == 59;
    dc = hc && (m_m12 ? (m_hr == 11 && m_pm) : m_hr == 23);
    mo = dc && m_date >= days_in(m_mon, m_yr);
    yc = mo && m_mon >= 12;
    if (te) m_sec = (m_sec + 1) % 60;
    if (mc) m_min = (m_min + 1) % 60;
    if (hc) begin
      if (m_m12) begin
        if (m_hr == 12) m_hr = 1;
        else if (m_hr == 11) begin m_hr = 12; m_pm = !m_pm; end
        else m_hr++;
      end else m_hr = (m_hr >= 23) ? 0 : m_hr + 1;
    end
    if (dc) begin
      m_dow  = (m_dow >= 7) ? 1 : m_dow + 1;
      m_date = mo ? 1 : m_date + 1;
    end
    if (mo) m_mon = yc ? 1 : m_mon + 1;
    if (yc) m_yr = (m_yr + 1) % 100;
    if (w) begin
      case (a)
        0: begin m_halt = d[7]; m_sec = from_bcd(d & 8'h7F); end
        1: m_min = from_bcd(d & 8'h7F);
        2: begin
             m_m12 = d[7];
             if (m_m12) begin m_pm = d[5]; m_hr = from_bcd(d & 8'h1F); end
             else begin m_pm = 0; m_hr = from_bcd(d & 8'h3F); end
           end
        3: m_date = from_bcd(d & 8'h3F);
        4: m_mon  = from_bcd(d & 8'h1F);
        5: m_dow  = d & 7;
        6: m_yr   = from_bcd(d);
        default: ;
      endcase
    end
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic rd(int a, output int v);
    rd_addr_i = a[2:0];
    #0.2;
    v = rd_data_o;
  endtask

  task automatic compare_all();
    int v;
    for (int a = 0; a < 7; a++) begin
      rd(a, v);
      check(tag_of(a), $sformatf("field %0d", a), v, image(a));
    end
  endtask

  // one clock: drive, edge, update model, sample after the edge
  task automatic cyc(bit t, bit w, int a, int d);
    tick_i = t; wr_en_i = w; wr_addr_i = a[2:0]; wr_data_i = d[7:0];
    @(posedge clk);
    model_step(t, w, a, d);
    #0.3;
    tick_i = 0; wr_en_i = 0;
    compare_all();
  endtask

  task automatic load(int s, int mi, int h, int dt, int mo, int dw, int y);
    cyc(0, 1, 6, y);  cyc(0, 1, 4, mo); cyc(0, 1, 3, dt);
    cyc(0, 1, 5, dw); cyc(0, 1, 2, h);  cyc(0, 1, 1, mi);
    cyc(0, 1, 0, s);
  endtask

  task automatic expect_field(string req, int a, int exp);
    int v;
    rd(a, v);
    check(req, $sformatf("direct field %0d", a), v, exp);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'd20240611));
    m_sec = 0; m_min = 0; m_hr = 0; m_date = 1; m_mon = 1; m_dow = 1; m_yr = 0;
    m_halt = 0; m_m12 = 0; m_pm = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset images
    expect_field("R1", 0, 8'h00); expect_field("R1", 1, 8'h00);
    expect_field("R1", 2, 8'h00); expect_field("R1", 3, 8'h01);
    expect_field("R1", 4, 8'h01); expect_field("R1", 5, 8'h01);
    expect_field("R1", 6, 8'h00);

    // R2 plain count
    cyc(1, 0, 0, 0); expect_field("R2", 0, 8'h01);

    // R3 R7 R8 full rollover on 31 Dec 99 23:59:59
    load(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 7, 8'h99);
    cyc(1, 0, 0, 0);
    expect_field("R3", 2, 8'h00); expect_field("R7", 4, 8'h01);
    expect_field("R7", 6, 8'h00); expect_field("R8", 5, 8'h01);
    expect_field("R5", 3, 8'h01);

    // R6 leap February in year 24 and year 00, common in 23
    load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 3, 8'h24);
    cyc(1, 0, 0, 0); expect_field("R6", 3, 8'h29);
    cyc(0, 1, 2, 8'h23); cyc(0, 1, 1, 8'h59); cyc(0, 1, 0, 8'h59);
    cyc(1, 0, 0, 0); expect_field("R6", 3, 8'h01); expect_field("R6", 4, 8'h03);
    load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 3, 8'h23);
    cyc(1, 0, 0, 0); expect_field("R6", 3, 8'h01);
    load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 3, 8'h00);
    cyc(1, 0, 0, 0); expect_field("R6", 3, 8'h29);

    // R5 30-day month
    load(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 2, 8'h31);
    cyc(1, 0, 0, 0); expect_field("R5", 3, 8'h01); expect_field("R5", 4, 8'h05);

    // R4 12-hour turns
    load(8'h59, 8'h59, 8'h91, 8'h10, 8'h05, 2, 8'h31);
    cyc(1, 0, 0, 0); expect_field("R4", 2, 8'hB2); expect_field("R4", 3, 8'h10);
    cyc(0, 1, 1, 8'h59); cyc(0, 1, 0, 8'h59);
    cyc(1, 0, 0, 0); expect_field("R4", 2, 8'hA1);
    load(8'h59, 8'h59, 8'hB1, 8'h10, 8'h05, 2, 8'h31);
    cyc(1, 0, 0, 0); expect_field("R4", 2, 8'h92); expect_field("R4", 3, 8'h11);

    // R9 halt
    cyc(0, 1, 0, 8'h85);
    repeat (5) cyc(1, 0, 0, 0);
    expect_field("R9", 0, 8'h85);
    cyc(0, 1, 0, 8'h05); cyc(1, 0, 0, 0); expect_field("R9", 0, 8'h06);

    // R10 write against tick
    cyc(0, 1, 0, 8'h59); cyc(0, 1, 1, 8'h20);
    cyc(1, 1, 0, 8'h40); expect_field("R10", 0, 8'h40); expect_field("R10", 1, 8'h21);

    // R11 masked bits and empty address
    cyc(0, 1, 1, 8'hB0); expect_field("R11", 1, 8'h30);
    cyc(0, 1, 2, 8'h52); expect_field("R11", 2, 8'h12);
    rd(7, v); check("R11", "address 7", v, 8'h00);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r, a, d;
      r = $urandom % 100;
      a = $urandom % 7;
      case (a)
        0: d = (($urandom % 10 == 0) ? 8'h80 : 0) | to_bcd(($urandom % 2) ? 55 + $urandom % 5 : $urandom % 60);
        1: d = to_bcd(($urandom % 2) ? 59 : $urandom % 60);
        2: if ($urandom % 2) d = 8'h80 | (($urandom % 2) << 5) | to_bcd(($urandom % 2) ? 11 + $urandom % 2 : 1 + $urandom % 12);
           else d = to_bcd(($urandom % 2) ? 23 : $urandom % 24);
        3: d = to_bcd(1 + $urandom % 28);
        4: d = to_bcd(1 + $urandom % 12);
        5: d = 1 + $urandom % 7;
        default: d = to_bcd($urandom % 100);
      endcase
      if (r < 70) cyc(1, 0, 0, 0);
      else if (r < 80) cyc(1, 1, a, d);
      else if (r < 95) cyc(0, 1, a, d);
      else cyc(0, 0, 0, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule